// File: doc/BRIEF.md
# Multi-Lane Serial NAND Register Engine

This block lets software drive a serial NAND flash one short phase at a time. Each phase is an opcode, an address, dummy cycles or data, and it moves 1 to 4 bytes over one, two or four data lines. Software first programs a command word that holds the byte count minus one and a lane-width code. It then writes the outgoing data word, or starts an incoming transfer by writing the read command. Software polls a busy flag before issuing the next phase. Longer phases are split by software into repeated 4-byte transfers.

Chip selects are held in their own register, so a select stays active across any number of phases until software releases it. The serial clock idles low and follows SPI mode 0: data changes on the falling edge and is sampled on the rising edge. The clock is a fixed division of the system clock. Data lines are driven only while bits go out, and only the lines the selected width uses.

Register word offsets: chip select 0x00, outgoing command 0x04, incoming command 0x08, read data 0x0C, outgoing data 0x10, status 0x14.

Top module: `snand_lane_ctrl`

## Requirements
- R1: After reset, every chip select is deasserted (high), the serial clock is low, no data line is driven, the status busy bit reads 0 and the read-data register reads 0.
- R2: Chip select n is low exactly when bit 4·n of the chip-select register is 0. Writing all ones deasserts every select. A select holds its level across transfers until the register is written again.
- R3: The outgoing and incoming command words carry the byte count minus one in bits 1:0 and a lane-width code in bits 29:28. Code 0 selects 1 line, code 1 selects 2 lines, code 2 selects 4 lines, and code 3 is treated as 4 lines. The outgoing command reads back with exactly these fields.
- R4: Writing the outgoing data register starts an outgoing transfer that uses the stored outgoing command. Bytes leave from bits 31:24 downward, most significant bit first. A single-lane transfer uses line 0.
- R5: In dual or quad mode, the higher-numbered line carries the more significant bit of each group. A transfer of B bytes on L lines produces exactly 8·B/L serial clock pulses.
- R6: Writing the incoming command starts an incoming transfer. A single-lane read samples line 1. The received bytes are packed into the read-data register from bits 31:24 downward, and any unused low bytes read 0.
- R7: During an incoming transfer no data line is driven. During an outgoing transfer, exactly the lowest L lines are driven, where L is the lane count.
- R8: Status bit 3 reads 1 from the cycle after a transfer starts until the final falling clock edge, and the serial clock is low whenever the block is idle.
- R9: While the block is busy, writes to any register are ignored: the chip selects, the stored commands, and the number of clock pulses are all left unchanged.
- R10: An outgoing transfer with data value zero acts as dummy cycles. It produces the requested number of pulses at the requested width, with the driven lines held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational) |
| sck_o | output | 1 | Serial clock, mode 0 |
| cs_no | output | 2 | Chip selects, active low |
| sio_i | input | 4 | Data line input values |
| sio_o | output | 4 | Data line output values |
| sio_oe_o | output | 4 | Data line output enables |

## Verification
The assertions check on every cycle that a chip select never changes while a transfer runs, that the clock stays low and the lines stay released when the block is idle, that the enable pattern is always 1, 2 or 4 low lines, that data is steady while the clock is high, and that a start always raises busy. Only the bench scenarios can show bit ordering across lanes, pulse counts per length and width, left-aligned packing of received bytes, the handling of width code 3, and the absence of a second transfer after writes made during busy. The bench shows these with a flash model that records and supplies bits on the serial clock edges.

// File: rtl/snand_pkg.sv
package snand_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BUSY_BIT = 3;
  localparam int unsigned LW_LSB   = 28;

  typedef enum logic [1:0] {LW_X1 = 2'd0, LW_X2 = 2'd1, LW_X4 = 2'd2, LW_X4B = 2'd3} lane_w_e;

  typedef struct packed {
    logic              rx;
    logic [1:0]        len_m1;
    lane_w_e           lw;
    logic [WORD_W-1:0] data;
  } xfer_t;

  // word index of each register
  localparam logic [3:0] REG_CSEL = 4'd0;
  localparam logic [3:0] REG_WCMD = 4'd1;
  localparam logic [3:0] REG_RCMD = 4'd2;
  localparam logic [3:0] REG_RDAT = 4'd3;
  localparam logic [3:0] REG_WDAT = 4'd4;
  localparam logic [3:0] REG_STAT = 4'd5;

  function automatic logic [1:0] lane_shift(lane_w_e w);
    case (w)
      LW_X1:   return 2'd0;
      LW_X2:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/snand_regs.sv
module snand_regs
  import snand_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NUM_CS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  input  logic              busy_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic [NUM_CS-1:0] cs_no,
  output logic              start_o,
  output xfer_t             xfer_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [WORD_W-1:0] csel_q;
  logic [1:0]        wlen_q;
  lane_w_e           wlw_q;
  logic [IDX_W-1:0]  idx;
  logic              wr_ok;

  assign idx   = bus_addr_i[ADDR_W-1:2];
  assign wr_ok = bus_req_i & bus_we_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csel_q <= '1;
      wlen_q <= 2'd0;
      wlw_q  <= LW_X1;
    end else if (wr_ok) begin
      if (idx == IDX_W'(REG_CSEL)) csel_q <= bus_wdata_i;
      if (idx == IDX_W'(REG_WCMD)) begin
        wlen_q <= bus_wdata_i[1:0];
        wlw_q  <= lane_w_e'(bus_wdata_i[LW_LSB+1:LW_LSB]);
      end
    end
  end

  assign start_o = wr_ok && (idx == IDX_W'(REG_WDAT) || idx == IDX_W'(REG_RCMD));

  always_comb begin
    if (idx == IDX_W'(REG_RCMD)) begin
      xfer_o.rx     = 1'b1;
      xfer_o.len_m1 = bus_wdata_i[1:0];
      xfer_o.lw     = lane_w_e'(bus_wdata_i[LW_LSB+1:LW_LSB]);
      xfer_o.data   = '0;
    end else begin
      xfer_o.rx     = 1'b0;
      xfer_o.len_m1 = wlen_q;
      xfer_o.lw     = wlw_q;
      xfer_o.data   = bus_wdata_i;
    end
  end

  generate
    for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
      assign cs_no[n] = csel_q[4*n];
    end
  endgenerate

  always_comb begin
    bus_rdata_o = '0;
    case (idx)
      IDX_W'(REG_CSEL): bus_rdata_o = csel_q;
      IDX_W'(REG_WCMD): begin
        bus_rdata_o[1:0]               = wlen_q;
        bus_rdata_o[LW_LSB+1:LW_LSB]   = wlw_q;
      end
      IDX_W'(REG_RDAT): bus_rdata_o = rx_word_i;
      IDX_W'(REG_STAT): bus_rdata_o[BUSY_BIT] = busy_i;
      default:          bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/snand_clkgen.sv
module snand_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CNT_W-1:0] div_q;
  logic             sck_q;
  logic             wrap;

  assign wrap   = en_i && (div_q == CNT_W'(HALF_DIV - 1));
  assign rise_o = wrap && !sck_q;
  assign fall_o = wrap && sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else if (!en_i) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else if (wrap) begin
      div_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/snand_shifter.sv
module snand_shifter
  import snand_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  xfer_t             xfer_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [LANES-1:0]  sio_i,
  output logic [LANES-1:0]  sio_o,
  output logic [LANES-1:0]  sio_oe_o,
  output logic              busy_o,
  output logic [WORD_W-1:0] rx_word_o
);
  logic [WORD_W-1:0] sh_q, sh_next, rxw_q;
  logic [5:0]        steps_q;
  logic [5:0]        steps_init;
  logic              busy_q, rx_q;
  lane_w_e           lw_q;
  logic [1:0]        len_q;
  logic [3:0]        samp_q, samp_d;
  int unsigned       nl;

  assign steps_init = {3'(xfer_i.len_m1) + 3'd1, 3'b000} >> lane_shift(xfer_i.lw);

  always_comb begin
    case (lw_q)
      LW_X1:   samp_d = {3'b000, sio_i[1]};
      LW_X2:   samp_d = {2'b00, sio_i[1:0]};
      default: samp_d = sio_i[3:0];
    endcase
    case (lw_q)
      LW_X1:   sh_next = {sh_q[WORD_W-2:0], samp_q[0]};
      LW_X2:   sh_next = {sh_q[WORD_W-3:0], samp_q[1:0]};
      default: sh_next = {sh_q[WORD_W-5:0], samp_q};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      rxw_q   <= '0;
      steps_q <= '0;
      busy_q  <= 1'b0;
      rx_q    <= 1'b0;
      lw_q    <= LW_X1;
      len_q   <= 2'd0;
      samp_q  <= '0;
    end else if (start_i && !busy_q) begin
      sh_q    <= xfer_i.data;
      steps_q <= steps_init;
      busy_q  <= 1'b1;
      rx_q    <= xfer_i.rx;
      lw_q    <= xfer_i.lw;
      len_q   <= xfer_i.len_m1;
      samp_q  <= '0;
    end else if (busy_q) begin
      if (rise_i) samp_q <= samp_d;
      if (fall_i) begin
        sh_q    <= sh_next;
        steps_q <= steps_q - 6'd1;
        if (steps_q == 6'd1) begin
          busy_q <= 1'b0;
          // left-align received bytes
          if (rx_q) rxw_q <= sh_next << {~len_q, 3'b000};
        end
      end
    end
  end

  always_comb begin
    case (lw_q)
      LW_X1:   nl = 1;
      LW_X2:   nl = 2;
      default: nl = 4;
    endcase
    sio_o    = '0;
    sio_oe_o = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(nl)) begin
        sio_o[k]    = sh_q[WORD_W - nl + k];
        sio_oe_o[k] = busy_q && !rx_q;
      end
    end
  end

  assign busy_o    = busy_q;
  assign rx_word_o = rxw_q;
endmodule

// File: rtl/snand_lane_ctrl.sv
module snand_lane_ctrl
  import snand_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int NUM_CS   = 2,
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              sck_o,
  output logic [NUM_CS-1:0] cs_no,
  input  logic [3:0]        sio_i,
  output logic [3:0]        sio_o,
  output logic [3:0]        sio_oe_o
);
  logic              busy;
  logic              xfer_start;
  xfer_t             xfer;
  logic [WORD_W-1:0] rx_word;
  logic              sck_rise, sck_fall;

  snand_regs #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_req_i   (bus_req_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .busy_i      (busy),
    .rx_word_i   (rx_word),
    .cs_no       (cs_no),
    .start_o     (xfer_start),
    .xfer_o      (xfer)
  );

  snand_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy),
    .sck_o  (sck_o),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  snand_shifter #(.LANES(4)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (xfer_start),
    .xfer_i    (xfer),
    .rise_i    (sck_rise),
    .fall_i    (sck_fall),
    .sio_i     (sio_i),
    .sio_o     (sio_o),
    .sio_oe_o  (sio_oe_o),
    .busy_o    (busy),
    .rx_word_o (rx_word)
  );
endmodule

// File: rtl/snand_lane_ctrl_chk.sv
module snand_lane_ctrl_chk #(
  parameter int NUM_CS = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy,
  input logic              xfer_start,
  input logic              sck_o,
  input logic [NUM_CS-1:0] cs_no,
  input logic [3:0]        sio_o,
  input logic [3:0]        sio_oe_o
);
  assert_cs_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(cs_no));

  assert_sck_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !sck_o);

  assert_start_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start |=> busy);

  assert_lanes_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (sio_oe_o == 4'b0000));

  assert_oe_shape_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sio_oe_o inside {4'b0000, 4'b0001, 4'b0011, 4'b1111});

  assert_data_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(sio_o));
endmodule

bind snand_lane_ctrl snand_lane_ctrl_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy       (busy),
  .xfer_start (xfer_start),
  .sck_o      (sck_o),
  .cs_no      (cs_no),
  .sio_o      (sio_o),
  .sio_oe_o   (sio_oe_o)
);

// File: tb/snand_lane_ctrl_tb.sv
module snand_lane_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck;
  logic [1:0]  cs_n;
  logic [3:0]  sio_in, sio_out, sio_oe;

  int          n_chk = 0, n_bad = 0;
  int          m_lanes = 1;
  logic [31:0] m_resp = '0, m_cap = '0;
  int          m_pulses = 0;
  logic [3:0]  m_oe_or = '0;

  localparam logic [5:0] A_CSEL = 6'h00, A_WCMD = 6'h04, A_RCMD = 6'h08,
                         A_RDAT = 6'h0C, A_WDAT = 6'h10, A_STAT = 6'h14;

  always #10 clk = ~clk;

  snand_lane_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .sck_o(sck), .cs_no(cs_n), .sio_i(sio_in), .sio_o(sio_out), .sio_oe_o(sio_oe)
  );

  // flash model: presents response bits, records driven bits
  always_comb begin
    case (m_lanes)
      1:       sio_in = {2'b00, m_resp[31], 1'b0};
      2:       sio_in = {2'b00, m_resp[31:30]};
      default: sio_in = m_resp[31:28];
    endcase
  end

  always @(posedge sck) begin
    m_pulses = m_pulses + 1;
    m_oe_or  = m_oe_or | sio_oe;
    if (sio_oe != 4'b0000) begin
      case (m_lanes)
        1:       m_cap = {m_cap[30:0], sio_out[0]};
        2:       m_cap = {m_cap[29:0], sio_out[1:0]};
        default: m_cap = {m_cap[27:0], sio_out};
      endcase
    end
  end

  always @(negedge sck) m_resp = m_resp << m_lanes;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int g = 0;
    do begin
      bus_read(A_STAT, v);
      g++;
    end while (v[3] && g < 5000);
  endtask

  task automatic model_clear(input int lanes, input logic [31:0] resp);
    m_lanes = lanes; m_resp = resp; m_cap = '0; m_pulses = 0; m_oe_or = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 cs", {30'd0, cs_n}, 32'h3);
    chk("R1 sck", {31'd0, sck}, 32'h0);
    chk("R1 oe", {28'd0, sio_oe}, 32'h0);
    bus_read(A_STAT, v); chk("R1 status", v, 32'h0);
    bus_read(A_RDAT, v); chk("R1 rdata", v, 32'h0);
  endtask

  task automatic t_csel();
    bus_write(A_CSEL, 32'hFFFF_FFEF);
    #1 chk("R2 cs1 select", {30'd0, cs_n}, 32'h1);
    bus_write(A_CSEL, 32'hFFFF_FFFF);
    #1 chk("R2 all off", {30'd0, cs_n}, 32'h3);
    bus_write(A_CSEL, 32'hFFFF_FFFE);
    #1 chk("R2 cs0 select", {30'd0, cs_n}, 32'h2);
  endtask

  task automatic t_tx(input string tag, input logic [1:0] len_m1, input logic [1:0] code,
                      input int lanes, input logic [31:0] data, input logic [31:0] exp_cap,
                      input int exp_pulses, input logic [3:0] exp_oe);
    model_clear(lanes, 32'h0);
    bus_write(A_WCMD, {2'b00, code, 26'd0, len_m1});
    bus_write(A_WDAT, data);
    wait_idle();
    chk({tag, " bits"}, m_cap, exp_cap);
    chk({tag, " pulses"}, m_pulses, exp_pulses);
    chk({tag, " lanes"}, {28'd0, m_oe_or}, {28'd0, exp_oe});
    chk("R2 cs held", {30'd0, cs_n}, 32'h2);
    chk("R8 sck idle", {31'd0, sck}, 32'h0);
  endtask

  task automatic t_rx(input string tag, input logic [1:0] len_m1, input logic [1:0] code,
                      input int lanes, input logic [31:0] resp, input logic [31:0] exp_word,
                      input int exp_pulses);
    logic [31:0] v;
    model_clear(lanes, resp);
    bus_write(A_RCMD, {2'b00, code, 26'd0, len_m1});
    wait_idle();
    bus_read(A_RDAT, v);
    chk({tag, " word"}, v, exp_word);
    chk({tag, " pulses"}, m_pulses, exp_pulses);
    chk("R7 rx released", {28'd0, m_oe_or}, 32'h0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    bus_write(A_WCMD, 32'h2000_0001);
    bus_read(A_WCMD, v);
    chk("R3 readback", v, 32'h2000_0001);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    model_clear(1, 32'h0);
    bus_write(A_WCMD, 32'h0000_0003);
    bus_write(A_WDAT, 32'hF00D_CAFE);
    bus_read(A_STAT, v);
    chk("R8 busy bit", v, 32'h8);
    bus_write(A_CSEL, 32'hFFFF_FFFF);
    bus_write(A_WCMD, 32'h2000_0000);
    bus_write(A_WDAT, 32'h1111_1111);
    bus_write(A_RCMD, 32'h0000_0000);
    chk("R9 cs kept", {30'd0, cs_n}, 32'h2);
    wait_idle();
    repeat (60) @(negedge clk);
    chk("R9 no extra pulses", m_pulses, 32);
    chk("R9 data intact", m_cap, 32'hF00D_CAFE);
    bus_read(A_WCMD, v);
    chk("R9 cmd kept", v, 32'h0000_0003);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_csel();
    t_tx("R4 x1 4B", 2'd3, 2'd0, 1, 32'h9F12_3456, 32'h9F12_3456, 32, 4'b0001);
    t_tx("R4 x1 3B", 2'd2, 2'd0, 1, 32'h1300_ABCD, 32'h0013_00AB, 24, 4'b0001);
    t_tx("R5 x4 2B", 2'd1, 2'd2, 4, 32'hA55A_0000, 32'h0000_A55A, 4, 4'b1111);
    t_tx("R5 x2 1B", 2'd0, 2'd1, 2, 32'hC300_0000, 32'h0000_00C3, 4, 4'b0011);
    t_tx("R10 dummy", 2'd0, 2'd2, 4, 32'h0, 32'h0, 2, 4'b1111);
    t_tx("R3 code3", 2'd0, 2'd3, 4, 32'h6900_0000, 32'h0000_0069, 2, 4'b1111);
    t_rx("R6 x1 4B", 2'd3, 2'd0, 1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32);
    t_rx("R6 x4 2B", 2'd1, 2'd2, 4, 32'h5AC3_9999, 32'h5AC3_0000, 4);
    t_rx("R6 x2 3B", 2'd2, 2'd1, 2, 32'h1234_56FF, 32'h1234_5600, 12);
    t_readback();
    t_busy();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule